// File: doc/BRIEF.md
# Pad Boundary Scan Register

This block places three boundary scan cells around one bidirectional, tri-state pad. One cell observes the value received from the pad. One cell drives the value sent to the pad. One cell drives the pad's output enable. Each cell has two flip-flops. The first stage either captures the functional signal or takes the serial scan bit. The second stage holds a stable value that can take over the pad or the core input in test mode. The three first stages form one serial path between a scan input and a scan output, so a tester can set and observe both the direction and the value of the pad.

The controller that sequences the test port is outside the block. Its strobes arrive as plain inputs: shift, capture, update and test mode, with the test clock. First stages change on the rising edge of the test clock. Second stages load on the falling edge, so the values presented to the pad and the core do not ripple while bits move through the chain.

Top module: `pad_scan_reg`

## Requirements
- R1: A low `rst_n`, sampled synchronously on both clock edges, clears all first-stage and second-stage flip-flops. While reset is held with `test_mode` high, `pad_out`, `pad_oe`, `core_in` and `scan_out` are all 0.
- R2: On a rising edge with `shift_en` high, each first stage takes the bit ahead of it in the order `scan_in` → receive cell → drive cell → enable cell. `scan_out` shows the enable cell's first stage, so a bit reaches `scan_out` three rising edges after it was presented.
- R3: On a rising edge with `capture_en` high and `shift_en` low, the receive cell loads `pad_in`, the drive cell loads `core_out` and the enable cell loads `core_oe`.
- R4: When `shift_en` and `capture_en` are both high, the cells shift and `capture_en` has no effect.
- R5: On a rising edge with `shift_en` and `capture_en` both low, every first stage keeps its value.
- R6: On a falling edge with `update_en` high, every second stage loads its first stage. With `update_en` low, every second stage keeps its value, including while the chain shifts.
- R7: With `test_mode` low, `core_in` equals `pad_in`, `pad_out` equals `core_out` and `pad_oe` equals `core_oe`, with no clock delay.
- R8: With `test_mode` high, `core_in`, `pad_out` and `pad_oe` take the second stages of the receive, drive and enable cells respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_in | input | 1 | Serial scan data into the receive cell |
| shift_en | input | 1 | Shift strobe for the first stages |
| capture_en | input | 1 | Capture strobe for the first stages |
| update_en | input | 1 | Update strobe for the second stages |
| test_mode | input | 1 | 1 selects the second stages onto the pad and core paths |
| core_out | input | 1 | Functional data from the core toward the pad |
| core_oe | input | 1 | Functional output enable from the core |
| pad_in | input | 1 | Value received from the pad |
| pad_out | output | 1 | Value driven onto the pad buffer |
| pad_oe | output | 1 | Enable of the pad's tri-state output buffer |
| core_in | output | 1 | Received pad value delivered to the core |
| scan_out | output | 1 | Serial scan data out of the enable cell |

## Verification
The bench drives shift and capture together to confirm that shift wins. A design that gave capture priority would load the functional signals into the chain, and `scan_out` would show the wrong bit. It shifts in test mode with update low, to catch second stages that follow the chain and let the pad toggle during a shift. It walks single bits down the chain to catch cells wired in the wrong order, which would show up as a bit leaving `scan_out` too early or too late. Random strobe and data mixes, including idle cycles, catch a first stage that fails to hold when no strobe is active.

// File: rtl/pad_scan_pkg.sv
// Shared constants for the pad boundary scan register.
// Assumes a single pad served by three cells; the indices fix the chain order.
package pad_scan_pkg;
    localparam int CELL_CNT = 3;   // cells in the chain
    localparam int IDX_RX   = 0;   // receive cell, nearest scan_in
    localparam int IDX_TX   = 1;   // drive cell
    localparam int IDX_EN   = 2;   // enable cell, nearest scan_out
endpackage

// File: rtl/scan_first_stage.sv
// First stage of a scan cell: captures the functional bit or shifts the serial bit.
// Assumes shift_en has priority over capture_en; changes on the rising test clock edge.
module scan_first_stage (
    input  logic tck,
    input  logic rst_n,
    input  logic ser_in,
    input  logic func_in,
    input  logic shift_en,
    input  logic capture_en,
    output logic stage_q
);
    logic next_d;

    // Select the value loaded on the next rising edge.
    always_comb begin
        if (shift_en)        next_d = ser_in;
        else if (capture_en) next_d = func_in;
        else                 next_d = stage_q;
    end

    // Register the selected value, clearing it under reset.
    always_ff @(posedge tck) begin
        if (!rst_n) stage_q <= 1'b0;
        else        stage_q <= next_d;
    end

    AST_SHIFT_LOAD: assert property (@(posedge tck) disable iff (!rst_n)
        shift_en |=> stage_q == $past(ser_in));                       // R2
    AST_SHIFT_WINS: assert property (@(posedge tck) disable iff (!rst_n)
        (shift_en && capture_en) |=> stage_q == $past(ser_in));       // R4
    AST_CAPTURE_LOAD: assert property (@(posedge tck) disable iff (!rst_n)
        (capture_en && !shift_en) |=> stage_q == $past(func_in));     // R3
    AST_IDLE_HOLD: assert property (@(posedge tck) disable iff (!rst_n)
        (!capture_en && !shift_en) |=> $stable(stage_q));             // R5
endmodule

// File: rtl/scan_update_stage.sv
// Second stage of a scan cell: copies the first stage when update is strobed.
// Assumes loading on the falling test clock edge so the output stays still during shifts.
module scan_update_stage (
    input  logic tck,
    input  logic rst_n,
    input  logic src_q,
    input  logic update_en,
    output logic hold_q
);
    // Load or keep the held value on the falling edge.
    always_ff @(negedge tck) begin
        if (!rst_n)         hold_q <= 1'b0;
        else if (update_en) hold_q <= src_q;
    end

    AST_UPDATE_LOAD: assert property (@(negedge tck) disable iff (!rst_n)
        update_en |=> hold_q == $past(src_q));                        // R6
    AST_UPDATE_HOLD: assert property (@(negedge tck) disable iff (!rst_n)
        !update_en |=> $stable(hold_q));                              // R6
endmodule

// File: rtl/scan_cell.sv
// One boundary scan cell: first stage, second stage and the mode selector.
// Assumes par_out must follow func_in with no delay when test_mode is low.
module scan_cell (
    input  logic tck,
    input  logic rst_n,
    input  logic ser_in,
    input  logic func_in,
    input  logic shift_en,
    input  logic capture_en,
    input  logic update_en,
    input  logic test_mode,
    output logic ser_out,
    output logic par_out
);
    logic held;

    scan_first_stage u_first (
        .tck        (tck),
        .rst_n      (rst_n),
        .ser_in     (ser_in),
        .func_in    (func_in),
        .shift_en   (shift_en),
        .capture_en (capture_en),
        .stage_q    (ser_out)
    );

    scan_update_stage u_second (
        .tck       (tck),
        .rst_n     (rst_n),
        .src_q     (ser_out),
        .update_en (update_en),
        .hold_q    (held)
    );

    // Choose between the functional path and the held test value.
    always_comb begin
        par_out = test_mode ? held : func_in;
    end
endmodule

// File: rtl/pad_scan_reg.sv
// Boundary scan register for one tri-state bidirectional pad.
// Chains the receive, drive and enable cells from scan_in to scan_out.
// Assumes the port controller supplies the shift, capture, update and mode strobes.
module pad_scan_reg
    import pad_scan_pkg::*;
(
    input  logic tck,
    input  logic rst_n,
    input  logic scan_in,
    input  logic shift_en,
    input  logic capture_en,
    input  logic update_en,
    input  logic test_mode,
    input  logic core_out,
    input  logic core_oe,
    input  logic pad_in,
    output logic pad_out,
    output logic pad_oe,
    output logic core_in,
    output logic scan_out
);
    logic [CELL_CNT-1:0] func_vec;
    logic [CELL_CNT-1:0] par_vec;
    logic [CELL_CNT-1:0] ser_vec;

    // Gather the functional sources of each cell.
    always_comb begin
        func_vec         = '0;
        func_vec[IDX_RX] = pad_in;
        func_vec[IDX_TX] = core_out;
        func_vec[IDX_EN] = core_oe;
    end

    for (genvar g = 0; g < CELL_CNT; g++) begin : g_cell
        logic link_in;
        if (g == 0) begin : g_head
            assign link_in = scan_in;
        end else begin : g_link
            assign link_in = ser_vec[g-1];
        end

        scan_cell u_cell (
            .tck        (tck),
            .rst_n      (rst_n),
            .ser_in     (link_in),
            .func_in    (func_vec[g]),
            .shift_en   (shift_en),
            .capture_en (capture_en),
            .update_en  (update_en),
            .test_mode  (test_mode),
            .ser_out    (ser_vec[g]),
            .par_out    (par_vec[g])
        );
    end

    // Route the cell outputs to the pad, the core and the chain tail.
    always_comb begin
        core_in  = par_vec[IDX_RX];
        pad_out  = par_vec[IDX_TX];
        pad_oe   = par_vec[IDX_EN];
        scan_out = ser_vec[CELL_CNT-1];
    end

    AST_BYPASS_PATH: assert property (@(posedge tck) disable iff (!rst_n)
        !test_mode |-> (pad_oe == core_oe && pad_out == core_out));   // R7
endmodule

// File: tb/test_pad_scan_reg.sv
module test_pad_scan_reg;
    logic tck = 1'b0;
    logic rst_n, scan_in, shift_en, capture_en, update_en, test_mode;
    logic core_out, core_oe, pad_in;
    logic pad_out, pad_oe, core_in, scan_out;

    int n_chk = 0;
    int n_fail = 0;
    logic [2:0] m_cap = '0;  // model first stages: [0] receive, [1] drive, [2] enable
    logic [2:0] m_upd = '0;  // model second stages

    always #5 tck = ~tck;

    pad_scan_reg i_pad_scan_reg (
        .tck(tck), .rst_n(rst_n), .scan_in(scan_in), .shift_en(shift_en),
        .capture_en(capture_en), .update_en(update_en), .test_mode(test_mode),
        .core_out(core_out), .core_oe(core_oe), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .core_in(core_in), .scan_out(scan_out)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    function automatic logic [2:0] next_cap(logic [2:0] cur);
        if (!rst_n)         return 3'b000;
        if (shift_en)       return {cur[1], cur[0], scan_in};
        if (capture_en)     return {core_oe, core_out, pad_in};
        return cur;
    endfunction

    function automatic logic sel(logic tm, logic held, logic fn);
        return tm ? held : fn;
    endfunction

    // One clock period with the current inputs; sample after the falling edge.
    task automatic step(input string req_ser, input string req_par);
        @(posedge tck);
        m_cap = next_cap(m_cap);
        if (!rst_n)         m_upd = 3'b000;
        else if (update_en) m_upd = m_cap;
        #8;
        chk(req_ser, "scan_out", scan_out, m_cap[2]);
        chk(req_par, "core_in",  core_in,  sel(test_mode, m_upd[0], pad_in));
        chk(req_par, "pad_out",  pad_out,  sel(test_mode, m_upd[1], core_out));
        chk(req_par, "pad_oe",   pad_oe,   sel(test_mode, m_upd[2], core_oe));
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 0; scan_in = 1; shift_en = 1; capture_en = 0; update_en = 1;
        test_mode = 1; core_out = 1; core_oe = 1; pad_in = 1;
        step("R1", "R1");
        step("R1", "R1");
        rst_n = 1; update_en = 0; test_mode = 0;
        // R2: walk a single one down the chain, mode 0 passthrough (R7)
        scan_in = 1; step("R2", "R7");
        scan_in = 0; pad_in = 0; core_out = 0; step("R2", "R7");
        core_oe = 0; step("R2", "R7");
        step("R2", "R7");
        // R5: hold with no strobe
        shift_en = 0; step("R5", "R7");
        // R3: capture functional values
        capture_en = 1; pad_in = 1; core_out = 0; core_oe = 1; step("R3", "R7");
        // R6: update then R8 test mode
        capture_en = 0; update_en = 1; step("R5", "R6");
        update_en = 0; test_mode = 1; pad_in = 0; core_out = 1; core_oe = 0; step("R5", "R8");
        // R4: shift wins over capture; R6 second stages hold while shifting
        shift_en = 1; capture_en = 1; scan_in = 0; step("R4", "R6");
        scan_in = 1; step("R4", "R6");
        step("R4", "R6");
        // random mix
        for (int i = 0; i < 400; i++) begin
            string rs;
            shift_en   = ($urandom % 3) == 0;
            capture_en = ($urandom % 3) == 0;
            update_en  = ($urandom % 4) == 0;
            test_mode  = ($urandom % 2) == 1;
            scan_in    = $urandom % 2;
            core_out   = $urandom % 2;
            core_oe    = $urandom % 2;
            pad_in     = $urandom % 2;
            rst_n      = ($urandom % 50) != 0;
            if (!rst_n)          rs = "R1";
            else if (shift_en)   rs = capture_en ? "R4" : "R2";
            else if (capture_en) rs = "R3";
            else                 rs = "R5";
            step(rs, test_mode ? "R8,R6" : "R7");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule